// File: doc/BRIEF.md
# Typed 32-bit Integer ALU

This block is a 32-bit integer arithmetic and logic unit with one register stage. It takes an 8-bit opcode from 0x40 to 0x56, a left operand, a right operand, an incoming carry, a 3-bit operand type and an extend-result flag. It returns a 32-bit result, the four condition flags (negative, zero, carry, overflow) and a destination write-enable. The right operand is always narrowed to the selected type and widened back to 32 bits, by sign extension or zero fill, before the operation. The operation itself always runs on the full 32 bits.

The block serves an execute stage. The load, store and load-and-jump opcodes only pass the shaped right operand through; memory access happens elsewhere. Compare and bit-test set the flags the same way as subtract and AND, but they do not request a register write. When the extend flag is set, the result is narrowed and widened again according to the same type before it leaves the block.

Top module: `typed_alu`

## Requirements
- R1: Opcodes 0x40, 0x41 and 0x56 output the shaped right operand as the result, assert the write-enable, and clear C and V.
- R2: Operand type codes: 0 is signed byte, 1 is unsigned byte, 2 is signed 16-bit, 3 is unsigned 16-bit, and 4 to 7 are the full 32-bit word. The right operand takes its low 8 or 16 bits. The upper bits are filled from the top kept bit for signed types and with zeros for unsigned types.
- R3: 0x42 computes left+right and 0x43 computes left+right+carry_in. C is the carry out of bit 31 and V is signed overflow.
- R4: 0x44 computes left-right, 0x45 computes left-right-carry_in, 0x46 computes right-left and 0x47 computes right-left-carry_in. C is set when an unsigned borrow occurs, and V is signed overflow.
- R5: 0x48 gives the same flags as 0x44, and 0x49 gives the same result and flags as 0x4A. Neither asserts the write-enable.
- R6: 0x4A AND, 0x4B OR and 0x4C XOR give the bitwise result with C and V cleared.
- R7: The shift amount is the shaped right operand bits [4:0]. 0x4D shifts left, 0x4F shifts right arithmetically and 0x50 shifts right inserting zeros. C holds the last bit shifted out, or 0 for an amount of zero. V is 0.
- R8: 0x4E and 0x51 rotate the 33-bit value formed by C and the left operand, left or right by the amount. Each step moves the bit leaving the word into C and the old C into the vacated bit. An amount of zero returns the operand and carry_in. V is 0.
- R9: 0x52 signed minimum, 0x53 unsigned minimum, 0x54 signed maximum and 0x55 unsigned maximum, with C and V cleared.
- R10: With ext_res set, the final result is narrowed and widened according to op_type in the same way as the right operand. C and V still come from the 32-bit operation.
- R11: For every operation, N equals bit 31 of the delivered result and Z is set exactly when the delivered result is zero.
- R12: Outputs update on the clock edge after in_valid is high. When in_valid is low, out_valid and wr_en go low on the next edge.
- R13: An opcode outside 0x40 to 0x56 returns result 0 with Z set, N, C and V clear, and no write-enable.
- R14: While reset is active, out_valid, wr_en, result and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request this cycle |
| opcode | input | 8 | Operation code |
| lhs | input | 32 | Left operand |
| rhs | input | 32 | Right operand before type shaping |
| carry_in | input | 1 | Incoming carry or borrow |
| op_type | input | 3 | Operand type code |
| ext_res | input | 1 | Shape the result by type as well |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow / shifted-out bit |
| flag_v | output | 1 | Signed overflow |
| wr_en | output | 1 | Destination write request |

## Verification
The clocked properties assume that in_valid, opcode, op_type and ext_res carry known values in every cycle after reset, because each property samples them whenever in_valid is high. The register stage is the only state in the block, so the properties look exactly one edge ahead. The random stimulus draws opcodes only from the valid range and type codes only from 0 to 4. Operand values are biased toward zero, all ones and the signed extremes. Out-of-range opcodes and type codes above 4 appear only in a few directed cases, with every input held at a defined value.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 16;
  localparam int OP_W    = 8;
  localparam int TYPE_W  = 3;
  localparam int SHAMT_W = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [OP_W-1:0] {
    OP_LD = 8'h40, OP_ST, OP_ADD, OP_ADC, OP_SUB, OP_SUBC, OP_SUBR, OP_SUBRC,
    OP_CMP, OP_BIT, OP_AND, OP_OR, OP_XOR, OP_SL, OP_SLC, OP_SR, OP_USR,
    OP_SRC, OP_MIN, OP_UMIN, OP_MAX, OP_UMAX, OP_LDJ
  } alu_op_e;

  typedef enum logic [TYPE_W-1:0] {
    TY_SBYTE = 3'd0, TY_UBYTE = 3'd1, TY_SHALF = 3'd2, TY_UHALF = 3'd3, TY_WORD = 3'd4
  } opnd_type_e;

  typedef struct packed {
    word_t value;
    logic  c;
    logic  v;
  } unit_res_t;

  // Narrow to the type and widen back to a full word.
  function automatic word_t shape_word(word_t v, logic [TYPE_W-1:0] ty);
    case (ty)
      TY_SBYTE: return {{(DATA_W-BYTE_W){v[BYTE_W-1]}}, v[BYTE_W-1:0]};
      TY_UBYTE: return {{(DATA_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
      TY_SHALF: return {{(DATA_W-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]};
      TY_UHALF: return {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
      default:  return v;
    endcase
  endfunction

  // Adder shared by add and subtract; subtract inverts y and reports borrow.
  function automatic unit_res_t add_sub(word_t x, word_t y, logic cin_eff, logic is_sub);
    unit_res_t r;
    logic [DATA_W:0] s;
    word_t yy;
    yy = is_sub ? ~y : y;
    s = {1'b0, x} + {1'b0, yy} + {{DATA_W{1'b0}}, cin_eff};
    r.value = s[DATA_W-1:0];
    r.c = is_sub ? ~s[DATA_W] : s[DATA_W];
    r.v = (x[DATA_W-1] == yy[DATA_W-1]) && (s[DATA_W-1] != x[DATA_W-1]);
    return r;
  endfunction
endpackage

// File: rtl/alu_shaper.sv
module alu_shaper
  import alu_pkg::*;
(
  input  word_t             din,
  input  logic [TYPE_W-1:0] ty,
  input  logic              en,
  output word_t             dout
);
  assign dout = en ? shape_word(din, ty) : din;
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  word_t           a,
  input  word_t           b,
  input  logic            cin,
  output unit_res_t       res,
  output logic            hit
);
  logic is_sub, swap, use_c, cin_eff;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_SUBR) ||
             (op == OP_SUBRC) || (op == OP_CMP);
    swap   = (op == OP_SUBR) || (op == OP_SUBRC);
    use_c  = (op == OP_ADC) || (op == OP_SUBC) || (op == OP_SUBRC);
    hit    = is_sub || (op == OP_ADD) || (op == OP_ADC);
    // subtract adds ~y + 1 - borrow
    if (is_sub) cin_eff = use_c ? ~cin : 1'b1;
    else        cin_eff = use_c ? cin : 1'b0;
    res = swap ? add_sub(b, a, cin_eff, is_sub) : add_sub(a, b, cin_eff, is_sub);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
(
  input  logic [OP_W-1:0]    op,
  input  word_t              a,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               cin,
  output unit_res_t          res,
  output logic               hit
);
  localparam int ROT_W = DATA_W + 1;

  logic [DATA_W:0]      left_w, right_w;
  logic [2*ROT_W-1:0]   rot_l, rot_r;
  logic [ROT_W-1:0]     rl, rr;

  always_comb begin
    // extra bit catches the last bit shifted out
    left_w = {1'b0, a} << amt;
    if (op == OP_SR) right_w = $unsigned($signed({a, 1'b0}) >>> amt);
    else             right_w = {a, 1'b0} >> amt;
    // 33-bit rotates through carry via a doubled vector
    rot_l = {{cin, a}, {cin, a}} << amt;
    rot_r = {{a, cin}, {a, cin}} >> amt;
    rl = rot_l[2*ROT_W-1:ROT_W];
    rr = rot_r[ROT_W-1:0];

    hit = 1'b1;
    res = '0;
    case (op)
      OP_SL:            begin res.value = left_w[DATA_W-1:0]; res.c = left_w[DATA_W]; end
      OP_SR, OP_USR:    begin res.value = right_w[DATA_W:1];  res.c = right_w[0];      end
      OP_SLC:           begin res.value = rl[DATA_W-1:0];     res.c = rl[DATA_W];      end
      OP_SRC:           begin res.value = rr[DATA_W:1];       res.c = rr[0];           end
      default:          hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  word_t           a,
  input  word_t           b,
  output unit_res_t       res,
  output logic            hit
);
  logic s_lt, u_lt;

  always_comb begin
    s_lt = $signed(a) < $signed(b);
    u_lt = a < b;
    hit = 1'b1;
    res = '0;
    case (op)
      OP_AND, OP_BIT: res.value = a & b;
      OP_OR:          res.value = a | b;
      OP_XOR:         res.value = a ^ b;
      OP_MIN:         res.value = s_lt ? a : b;
      OP_UMIN:        res.value = u_lt ? a : b;
      OP_MAX:         res.value = s_lt ? b : a;
      OP_UMAX:        res.value = u_lt ? b : a;
      default:        hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/typed_alu.sv
module typed_alu
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              carry_in,
  input  logic [TYPE_W-1:0] op_type,
  input  logic              ext_res,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic              wr_en
);
  word_t     rhs_typed, final_val;
  unit_res_t arith_res, shift_res, bw_res, raw;
  logic      arith_hit, shift_hit, bw_hit, pass_hit, op_known, cmp_like;

  alu_shaper u_rhs_shape (.din(rhs), .ty(op_type), .en(1'b1), .dout(rhs_typed));

  alu_arith u_arith (.op(opcode), .a(lhs), .b(rhs_typed), .cin(carry_in),
                     .res(arith_res), .hit(arith_hit));
  alu_shift u_shift (.op(opcode), .a(lhs), .amt(rhs_typed[SHAMT_W-1:0]), .cin(carry_in),
                     .res(shift_res), .hit(shift_hit));
  alu_bitwise u_bw (.op(opcode), .a(lhs), .b(rhs_typed), .res(bw_res), .hit(bw_hit));

  assign pass_hit = (opcode == OP_LD) || (opcode == OP_ST) || (opcode == OP_LDJ);
  assign op_known = pass_hit || arith_hit || shift_hit || bw_hit;
  assign cmp_like = (opcode == OP_CMP) || (opcode == OP_BIT);

  always_comb begin
    raw = '0;
    if (pass_hit)       raw.value = rhs_typed;
    else if (arith_hit) raw = arith_res;
    else if (shift_hit) raw = shift_res;
    else if (bw_hit)    raw = bw_res;
  end

  alu_shaper u_res_shape (.din(raw.value), .ty(op_type), .en(ext_res), .dout(final_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && op_known && !cmp_like;
      if (in_valid) begin
        result <= final_val;
        flag_n <= final_val[DATA_W-1];
        flag_z <= (final_val == '0);
        flag_c <= raw.c;
        flag_v <= raw.v;
      end
    end
  end

  // Exactly one functional unit claims a known opcode.
  AST_ONE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0({pass_hit, arith_hit, shift_hit, bw_hit})); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R12
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en)); // R12
  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == OP_CMP || opcode == OP_BIT)) |=> !wr_en); // R5
  AST_LOGIC_CLEAR_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR)) |=> (!flag_c && !flag_v)); // R6
  AST_EXT_UBYTE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ext_res && op_type == TY_UBYTE) |=> (result[DATA_W-1:BYTE_W] == '0)); // R10
  AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode < OP_LD || opcode > OP_LDJ)) |=> (!wr_en && result == '0 && flag_z)); // R13
endmodule

// File: tb/typed_alu_test.sv
`timescale 1ns/1ps
module typed_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h40;
  logic [31:0] lhs = '0, rhs = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  op_type = 3'd4;
  logic        ext_res = 1'b0;
  logic        out_valid, flag_n, flag_z, flag_c, flag_v, wr_en;
  logic [31:0] result;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  typed_alu uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .lhs(lhs), .rhs(rhs), .carry_in(carry_in), .op_type(op_type), .ext_res(ext_res),
    .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .wr_en(wr_en));

  // packed expectation: {result, n, z, c, v, wr}
  function automatic logic [31:0] fit(logic [31:0] b, logic [2:0] ty);
    logic [31:0] x;
    x = b;
    if (ty == 3'd0 || ty == 3'd1) begin
      x = b & 32'h0000_00FF;
      if (ty == 3'd0 && x[7]) x = x | 32'hFFFF_FF00;
    end else if (ty == 3'd2 || ty == 3'd3) begin
      x = b & 32'h0000_FFFF;
      if (ty == 3'd2 && x[15]) x = x | 32'hFFFF_0000;
    end
    return x;
  endfunction

  function automatic logic [36:0] model(logic [7:0] op, logic [31:0] a, logic [31:0] braw,
                                        logic ci, logic [2:0] ty, logic ext);
    logic [31:0] b, r, x, y;
    logic c, v, wr, nc;
    longint ut, st;
    int n;
    b = fit(braw, ty);
    r = '0; c = 0; v = 0; wr = 1;
    n = int'(b & 32'h1F);
    case (op)
      8'h40, 8'h41, 8'h56: r = b;
      8'h42, 8'h43: begin
        ut = longint'({32'b0, a}) + longint'({32'b0, b}) + ((op == 8'h43 && ci) ? 1 : 0);
        st = longint'($signed(a)) + longint'($signed(b)) + ((op == 8'h43 && ci) ? 1 : 0);
        r = ut[31:0]; c = ut > 64'sh0FFFF_FFFF;
        v = (st > 64'sd2147483647) || (st < -64'sd2147483648);
      end
      8'h44, 8'h45, 8'h46, 8'h47, 8'h48: begin
        if (op == 8'h46 || op == 8'h47) begin x = b; y = a; end else begin x = a; y = b; end
        ut = longint'({32'b0, x}) - longint'({32'b0, y}) - ((op inside {8'h45, 8'h47} && ci) ? 1 : 0);
        st = longint'($signed(x)) - longint'($signed(y)) - ((op inside {8'h45, 8'h47} && ci) ? 1 : 0);
        r = ut[31:0]; c = ut < 0;
        v = (st > 64'sd2147483647) || (st < -64'sd2147483648);
        if (op == 8'h48) wr = 0;
      end
      8'h49: begin r = a & b; wr = 0; end
      8'h4A: r = a & b;
      8'h4B: r = a | b;
      8'h4C: r = a ^ b;
      8'h4D, 8'h4F, 8'h50: begin
        r = a;
        for (int i = 0; i < n; i++) begin
          if (op == 8'h4D) begin c = r[31]; r = {r[30:0], 1'b0}; end
          else begin c = r[0]; r = {(op == 8'h4F) ? r[31] : 1'b0, r[31:1]}; end
        end
      end
      8'h4E, 8'h51: begin
        r = a; c = ci;
        for (int i = 0; i < n; i++) begin
          if (op == 8'h4E) begin nc = r[31]; r = {r[30:0], c}; end
          else begin nc = r[0]; r = {c, r[31:1]}; end
          c = nc;
        end
      end
      8'h52: r = ($signed(a) < $signed(b)) ? a : b;
      8'h53: r = (a < b) ? a : b;
      8'h54: r = ($signed(a) > $signed(b)) ? a : b;
      8'h55: r = (a > b) ? a : b;
      default: wr = 0;
    endcase
    if (ext && op >= 8'h40 && op <= 8'h56) r = fit(r, ty);
    return {r, r[31], r == 32'd0, c, v, wr};
  endfunction

  task automatic report(bit ok, string tag, logic [36:0] got, logic [36:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got r=%h nzcv=%b wr=%b, expected r=%h nzcv=%b wr=%b",
               tag, got[36:5], got[4:1], got[0], exp[36:5], exp[4:1], exp[0]);
    end
  endtask

  task automatic run_op(logic [7:0] op, logic [31:0] a, logic [31:0] b, logic ci,
                        logic [2:0] ty, logic ext, string tag);
    logic [36:0] exp, got;
    @(negedge clk);
    in_valid = 1; opcode = op; lhs = a; rhs = b; carry_in = ci; op_type = ty; ext_res = ext;
    exp = model(op, a, b, ci, ty, ext);
    @(negedge clk);
    got = {result, flag_n, flag_z, flag_c, flag_v, wr_en};
    report(out_valid && got == exp, tag, got, exp);
    in_valid = 0;
  endtask

  function automatic logic [31:0] pick_word();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return $urandom_range(0, 40);
      default: return $urandom;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] op);
    if (op inside {8'h40, 8'h41, 8'h56}) return "R1";
    if (op inside {8'h42, 8'h43}) return "R3";
    if (op inside {[8'h44:8'h47]}) return "R4";
    if (op inside {8'h48, 8'h49}) return "R5";
    if (op inside {[8'h4A:8'h4C]}) return "R6";
    if (op inside {8'h4D, 8'h4F, 8'h50}) return "R7";
    if (op inside {8'h4E, 8'h51}) return "R8";
    if (op inside {[8'h52:8'h55]}) return "R9";
    return "R13";
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    @(negedge clk);
    @(negedge clk);
    // R14 reset state
    report({out_valid, wr_en, result, flag_n, flag_z, flag_c, flag_v} == '0, "R14",
           {result, flag_n, flag_z, flag_c, flag_v, wr_en}, '0);
    rst_n = 1;

    // R1 / R2 pass-through with each type code
    run_op(8'h40, 32'h0, 32'h1234_5680, 0, 3'd0, 0, "R2");
    run_op(8'h40, 32'h0, 32'h1234_5680, 0, 3'd1, 0, "R2");
    run_op(8'h41, 32'h0, 32'hABCD_8001, 0, 3'd2, 0, "R2");
    run_op(8'h56, 32'h0, 32'hABCD_8001, 0, 3'd3, 0, "R2");
    run_op(8'h40, 32'h0, 32'hABCD_8001, 0, 3'd7, 0, "R2");
    // R3 add corners
    run_op(8'h42, 32'hFFFF_FFFF, 32'h1, 0, 3'd4, 0, "R3");
    run_op(8'h42, 32'h7FFF_FFFF, 32'h1, 0, 3'd4, 0, "R3");
    run_op(8'h43, 32'h1, 32'hFF, 1, 3'd0, 0, "R3");
    // R4 subtract family and borrow
    run_op(8'h44, 32'h1, 32'h2, 0, 3'd4, 0, "R4");
    run_op(8'h45, 32'h5, 32'h5, 1, 3'd4, 0, "R4");
    run_op(8'h46, 32'h3, 32'h10, 0, 3'd4, 0, "R4");
    run_op(8'h47, 32'h8000_0000, 32'h1, 1, 3'd4, 0, "R4");
    run_op(8'h44, 32'h8000_0000, 32'h1, 0, 3'd4, 0, "R4");
    // R5 compare and bit test, R11 zero result
    run_op(8'h48, 32'h42, 32'h42, 0, 3'd4, 0, "R5");
    run_op(8'h49, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 0, 3'd4, 0, "R11");
    // R6 logic
    run_op(8'h4B, 32'h8000_0000, 32'h1, 1, 3'd4, 0, "R6");
    run_op(8'h4C, 32'hFFFF_FFFF, 32'hFF, 1, 3'd0, 0, "R6");
    // R7 shifts including amount 0 and 31
    run_op(8'h4D, 32'hC000_0001, 32'h1, 0, 3'd4, 0, "R7");
    run_op(8'h4F, 32'h8000_0010, 32'h4, 0, 3'd4, 0, "R7");
    run_op(8'h50, 32'h8000_0010, 32'h1F, 0, 3'd4, 0, "R7");
    run_op(8'h4D, 32'hFFFF_FFFF, 32'h20, 1, 3'd4, 0, "R7");
    // R8 rotates through carry
    run_op(8'h4E, 32'h8000_0000, 32'h1, 1, 3'd4, 0, "R8");
    run_op(8'h51, 32'h0000_0001, 32'h1, 0, 3'd4, 0, "R8");
    run_op(8'h51, 32'h1234_5678, 32'h0, 1, 3'd4, 0, "R8");
    run_op(8'h4E, 32'hA5A5_0F0F, 32'h1F, 1, 3'd4, 0, "R8");
    // R9 min/max signed vs unsigned
    run_op(8'h52, 32'hFFFF_FFFF, 32'h1, 0, 3'd4, 0, "R9");
    run_op(8'h53, 32'hFFFF_FFFF, 32'h1, 0, 3'd4, 0, "R9");
    run_op(8'h54, 32'h5, 32'hFF, 0, 3'd0, 0, "R9");
    run_op(8'h55, 32'h5, 32'hFF, 0, 3'd0, 0, "R9");
    // R10 result extension
    run_op(8'h42, 32'h7F, 32'h1, 0, 3'd0, 1, "R10");
    run_op(8'h44, 32'h0, 32'h1, 0, 3'd3, 1, "R10");
    run_op(8'h42, 32'h100, 32'h0, 0, 3'd1, 1, "R10");
    // R13 unknown opcodes
    run_op(8'h3F, 32'h1, 32'h1, 1, 3'd4, 0, "R13");
    run_op(8'h57, 32'h1, 32'h1, 1, 3'd4, 1, "R13");
    // R12 idle cycle
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    report(!out_valid && !wr_en, "R12", {result, flag_n, flag_z, flag_c, flag_v, wr_en},
           {result, flag_n, flag_z, flag_c, flag_v, 1'b0});

    for (int k = 0; k < 4000; k++) begin
      logic [7:0] op;
      op = 8'(8'h40 + $urandom_range(0, 22));
      run_op(op, pick_word(), pick_word(), 1'($urandom_range(0, 1)),
             3'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), tag_of(op));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule